// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block multiplies two signed 8-bit operands on every accepted input beat. It sign-extends the 16-bit product and adds it into a 16-bit running-sum register. The register output feeds back into the adder, so after N accepted beats the output holds the sum of the N products, wrapped modulo 2^16. The addition goes through a per-bit half-adder carry-save stage. A ripple add then resolves the sum and carry vectors before the register captures the result.

The unit raises a flag when the running sum leaves the signed 16-bit range. The test is the sign rule: the two addends share a sign and the result has the other sign. The flag is sticky. It stays set until a synchronous clear, which also zeroes the register.

Operands arrive on a valid/ready handshake. The unit never stalls for its own reasons, because it accepts one beat per clock. The only back-pressure comes from the clear: while the clear is high, ready is low and any beat offered in that cycle is dropped. A beat is accepted in a cycle where both valid and ready are high.

Top module: `mac_acc`

## Requirements
- R1: When `clr` is high at a rising edge, `acc_out` becomes 0 and `ovf_flag` becomes 0 after that edge, whatever the other inputs are.
- R2: An accepted beat (valid and ready both high) adds the product of the two operands into the register at that edge. After the edge, `acc_out` equals the old value plus the product, modulo 2^16.
- R3: In a cycle where `in_valid` is low (and `clr` is low), `acc_out` and `ovf_flag` keep their values.
- R4: Operands are two's-complement: bit 7 is the sign. The 16-bit product is sign-extended before the add. So (-128)·(-128) adds +16384 and (-128)·127 adds -16256.
- R5: The register wraps modulo 2^16 and never saturates. For example, 16384 + 16384 gives 0x8000.
- R6: `ovf_flag` is set after an accepted beat whose addends (old register value and extended product) have equal bit-15 signs while the result's bit 15 differs. Once set, it stays set until R1 clears it.
- R7: An accepted beat whose addends have different signs never sets `ovf_flag`.
- R8: `in_ready` equals the inverse of `clr`. A beat offered while `clr` is high is not added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of the sum and the overflow flag |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Unit can take a beat this cycle (low during clear) |
| op_x | input | 8 | First signed operand |
| op_y | input | 8 | Second signed operand |
| acc_out | output | 16 | Running sum of products, two's complement |
| ovf_flag | output | 1 | Sticky signed-overflow indication |

## Verification
A wrong carry in the carry-save or resolving stage shows as a wrong `acc_out` in the cycle right after the faulty beat. The error never cancels, because the sum feeds back. A lost sign extension shows on the first beat with a negative product. A flaw in the overflow rule or its stickiness shows on `ovf_flag` one edge after the crossing beat, or on any later cycle before a clear. The bench compares both outputs and `in_ready` against a behavioural model on every clock. That way a divergence is caught in the cycle it first appears.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OP_W_DEF  = 8;
  localparam int unsigned ACC_W_DEF = 16;

  // Two addends of one sign that give a result of the other sign.
  function automatic logic sign_flip(input logic a_msb, input logic b_msb,
                                     input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned OP_W  = 8,
  parameter int unsigned ACC_W = 16
) (
  input  logic [OP_W-1:0]  x,
  input  logic [OP_W-1:0]  y,
  output logic [ACC_W-1:0] prod_ext
);
  localparam int unsigned PROD_W = 2 * OP_W;

  logic signed [PROD_W-1:0] prod_full;
  assign prod_full = $signed(x) * $signed(y);

  generate
    if (ACC_W > PROD_W) begin : g_extend
      assign prod_ext = {{(ACC_W-PROD_W){prod_full[PROD_W-1]}}, prod_full};
    end else begin : g_narrow
      assign prod_ext = prod_full[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_csa_add.sv
module mac_csa_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  // Half-adder stage: per-bit sum vector and a carry vector shifted up one.
  logic [W-1:0] hs;
  logic [W-1:0] hc_sh;
  // Resolving ripple chain.
  logic [W-1:0] rc;

  assign hc_sh[0] = 1'b0;
  assign rc[0]    = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign hs[i] = a[i] ^ b[i];
      if (i < W - 1) begin : g_carry
        assign hc_sh[i+1] = a[i] & b[i];
        assign rc[i+1]    = (hs[i] & hc_sh[i]) | (rc[i] & (hs[i] ^ hc_sh[i]));
      end
      assign sum[i] = hs[i] ^ hc_sh[i] ^ rc[i];
    end
  endgenerate
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int unsigned OP_W  = OP_W_DEF,
  parameter int unsigned ACC_W = ACC_W_DEF
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  op_x,
  input  logic [OP_W-1:0]  op_y,
  output logic [ACC_W-1:0] acc_out,
  output logic             ovf_flag
);
  localparam int unsigned MSB = ACC_W - 1;

  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] next_sum;
  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;
  logic             accept;
  logic             ovf_now;

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .x(op_x), .y(op_y), .prod_ext(prod)
  );

  mac_csa_add #(.W(ACC_W)) u_add (
    .a(acc_q), .b(prod), .sum(next_sum)
  );

  assign in_ready = ~clr;
  assign accept   = in_valid & in_ready;
  assign ovf_now  = sign_flip(acc_q[MSB], prod[MSB], next_sum[MSB]);

  always_ff @(posedge clk) begin
    if (clr) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (accept) begin
      acc_q <= next_sum;
      ovf_q <= ovf_q | ovf_now;
    end
  end

  assign acc_out  = acc_q;
  assign ovf_flag = ovf_q;

  // R1: clear empties the sum and the flag.
  p_clear_zero_r1: assert property (@(posedge clk)
    clr |=> (acc_q == '0 && !ovf_q));

  // R2: an accepted beat adds the extended product.
  p_sum_r2: assert property (@(posedge clk) disable iff (clr)
    accept |=> (acc_q == ACC_W'($past(acc_q) + $past(prod))));

  // R3: no beat, no change.
  p_hold_r3: assert property (@(posedge clk) disable iff (clr)
    !in_valid |=> ($stable(acc_q) && $stable(ovf_q)));

  // R6: the flag stays set until a clear.
  p_sticky_r6: assert property (@(posedge clk) disable iff (clr)
    ovf_q |=> ovf_q);

  // R7: addends of differing sign never raise the flag.
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (clr)
    (!ovf_q && accept && (acc_q[MSB] != prod[MSB])) |=> !ovf_q);
endmodule

// File: tb/test_mac_acc.sv
`timescale 1ns/1ps
module test_mac_acc;
  logic        clk = 1'b0;
  logic        clr;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  op_x;
  logic [7:0]  op_y;
  logic [15:0] acc_out;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_acc;
  logic        m_ovf;
  logic [15:0] lfsr;

  always #2.5 clk = ~clk;

  mac_acc i_mac_acc (
    .clk(clk), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .op_x(op_x), .op_y(op_y), .acc_out(acc_out), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge.
  task automatic step(input string tag, input logic c, input logic v,
                      input int x, input int y);
    int p;
    int s;
    clr = c; in_valid = v; op_x = 8'(x); op_y = 8'(y);
    #1;
    check({tag, " R8 ready"}, {15'd0, in_ready}, {15'd0, ~c});
    @(posedge clk);
    if (c) begin
      m_acc = '0; m_ovf = 1'b0;
    end else if (v) begin
      p = int'($signed(op_x)) * int'($signed(op_y));
      s = int'($signed(m_acc)) + p;
      if (s > 32767 || s < -32768) m_ovf = 1'b1;
      m_acc = 16'(s);
    end
    @(negedge clk);
    check({tag, " acc"}, acc_out, m_acc);
    check({tag, " R6 ovf"}, {15'd0, ovf_flag}, {15'd0, m_ovf});
  endtask

  initial begin
    clr = 1'b1; in_valid = 1'b0; op_x = '0; op_y = '0;
    m_acc = '0; m_ovf = 1'b0; lfsr = 16'hACE1;
    @(negedge clk);
    // R1: reset state
    step("R1 reset", 1, 0, 0, 0);
    check("R1 acc zero", acc_out, 16'h0000);
    // R2: simple positive products
    step("R2 basic", 0, 1, 3, 4);
    step("R2 basic", 0, 1, 5, 6);
    check("R2 sum 42", acc_out, 16'd42);
    // R3: idle cycles hold, inputs toggling
    step("R3 idle", 0, 0, 100, 100);
    step("R3 idle", 0, 0, -7, 9);
    check("R3 held", acc_out, 16'd42);
    // R4: sign extension corners
    step("R4 neg", 0, 1, -128, 127);
    check("R4 -16256+42", acc_out, 16'(42 - 16256));
    step("R4 negneg", 0, 1, -128, -128);
    check("R4 +16384", acc_out, 16'(42 - 16256 + 16384));
    // R8: beat offered during clear is dropped
    step("R8 drop", 1, 1, 50, 50);
    check("R8 dropped", acc_out, 16'h0000);
    // R5/R6: wrap and overflow
    step("R5 wrap", 0, 1, -128, -128);
    step("R5 wrap", 0, 1, -128, -128);
    check("R5 wrap 8000", acc_out, 16'h8000);
    check("R6 ovf set", {15'd0, ovf_flag}, 16'd1);
    // R7 / R6 sticky: differing-sign add does not clear or raise anything new
    step("R6 sticky", 0, 1, 1, 1);
    step("R6 sticky", 0, 0, 0, 0);
    check("R6 still set", {15'd0, ovf_flag}, 16'd1);
    step("R1 clear", 1, 0, 0, 0);
    check("R1 ovf cleared", {15'd0, ovf_flag}, 16'd0);
    // R7: large negative acc plus positive product, no overflow
    step("R7 setup", 0, 1, -128, 127);
    step("R7 setup", 0, 1, -128, 127);
    step("R7 mixed", 0, 1, 127, 127);
    check("R7 no ovf", {15'd0, ovf_flag}, 16'd0);
    // R2/R3/R6: pseudo-random mix
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R2 mix", (lfsr[15:11] == 5'd0), lfsr[0] | lfsr[1],
           int'($signed(lfsr[9:2])), int'($signed({lfsr[4:0], lfsr[15:13]})));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule